// File: doc/BRIEF.md
# Serial Command Port for a Multiplexed Seven-Segment Display Driver

This block is the command front end of a small multiplexed LED display controller. A host shifts 16-bit command words in on a serial clock and data line, most significant bit first. A rising edge on a load strobe commits the most recent 16 bits to one entry of a register file. The register file holds one segment byte for each digit, a per-digit decode-enable mask, a 4-bit brightness level, a scan-limit count, a run/sleep bit, an 8-bit feature byte and a lamp-test bit. The display scan logic reads these values straight from the output ports.

The serial pins come from outside the chip and are asynchronous. They pass through two-flop synchronizers into the system clock domain, and the block finds their edges there. A serial output carries each bit on to the next device, so several controllers can share one clock and one load line in a chain. Command words meant for a device further down the chain use the no-operation address, so the devices they pass through keep their state. When the chip-select feature bit is set, the load line also works as an active-low select: serial clock edges count only while it is low.

Two side effects tie the control registers together. A write to the run/sleep register clears the feature byte unless bit 7 of its data is set. While feature bit 1 is set, every control register except the feature byte is held at its power-up value, and the digit bytes keep their contents.

Top module: `segdrv_cmd_port`

## Requirements
- R1: Each command word is 16 bits, sent most significant bit first and sampled on rising serial clock edges. A rising edge on `load_i` commits the last 16 bits shifted in: address = word bits 11:8, data = word bits 7:0. Word bits 15:12 have no effect.
- R2: Address decode: 1, 2, 3 and 4 write digit bytes 0 to 3 (digit n sits in `digit_o[8n+7:8n]`). 9 writes `decode_en_o` from data bits 3:0. 10 writes `intensity_o` from data bits 3:0. 11 writes `scan_lim_o` from data bits 1:0. 12 sets `run_o` from data bit 0. 14 writes `feature_o` with the whole byte. 15 sets `test_o` from data bit 0.
- R3: A commit to address 0 (no-operation), to addresses 5 to 8, or to address 13 changes no output register.
- R4: `sdout_o` changes only on falling serial clock edges. After the falling edge that follows the k-th rising edge, it shows the bit that was shifted in on rising edge k-15.
- R5: After reset, every digit byte, `decode_en_o`, `intensity_o`, `scan_lim_o`, `run_o` (sleep), `feature_o`, `test_o` and `sdout_o` are all zero.
- R6: A write to address 12 clears `feature_o` when data bit 7 is 0 and leaves it unchanged when data bit 7 is 1.
- R7: While `feature_o` bit 1 is 1, `decode_en_o`, `intensity_o`, `scan_lim_o`, `run_o` and `test_o` stay at their reset values, and writes to them have no effect. Digit bytes and `feature_o` keep their values.
- R8: While `feature_o` bit 3 is 1 and `load_i` is high, serial clock edges are ignored: the shift register and `sdout_o` do not change.
- R9: Output registers change only after a rising edge on `load_i`. Serial clocking without such an edge changes none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdin_i | input | 1 | Serial data in, asynchronous |
| load_i | input | 1 | Load strobe / active-low select, asynchronous |
| sdout_o | output | 1 | Chain output |
| digit_o | output | 8*NUM_DIG | Digit segment bytes, digit n in bits 8n+7:8n |
| decode_en_o | output | NUM_DIG | Per-digit decode enable |
| intensity_o | output | 4 | Brightness level |
| scan_lim_o | output | clog2(NUM_DIG) | Index of the highest scanned digit |
| run_o | output | 1 | 1 = normal operation, 0 = sleep |
| feature_o | output | 8 | Feature byte |
| test_o | output | 1 | Lamp-test enable |

## Verification
Assertions check on every cycle that:
- digit bytes move only on a commit;
- the ignored addresses leave the whole register file untouched;
- run/sleep writes clear or keep the feature byte according to data bit 7;
- the held-at-default control registers stay at zero while feature bit 1 is set;
- the chain output moves only on falling serial clock edges;
- the shift register freezes when select gating is active.

Only the bench scenarios can show that complete words reach the right register with the right fields, that a commit takes exactly the last 16 bits after a longer burst, and that the chain output reproduces the input stream 16 edges later. They also show the gated-clock case end to end: clocking while deselected leaves both the outputs and a later re-commit unaffected.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int ADDR_LSB = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_NOP    = 4'h0,
        REG_DECODE = 4'h9,
        REG_BRIGHT = 4'hA,
        REG_SCAN   = 4'hB,
        REG_SLEEP  = 4'hC,
        REG_FEAT   = 4'hE,
        REG_LAMP   = 4'hF
    } reg_addr_e;

    localparam logic [ADDR_W-1:0] REG_DIG_BASE = 4'h1;
    localparam logic [ADDR_W-1:0] REG_SPARE    = 4'hD;

    localparam int FEAT_HOLD_CTL = 1;
    localparam int FEAT_CS_GATE  = 3;
    localparam int SLP_KEEP_FEAT = 7;
    localparam int SLP_RUN       = 0;
endpackage

// File: rtl/segdrv_sync.sv
module segdrv_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign level_o = s_q.stable;
endmodule

// File: rtl/segdrv_shifter.sv
module segdrv_shifter
    import segdrv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              sdin_i,
    input  logic              load_i,
    input  logic              cs_gate_i,
    output logic              commit_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              sdout_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic               so;
        logic               sclk_prev;
        logic               load_prev;
        logic               commit;
    } shf_t;

    shf_t s_d, s_q;
    logic sclk_rise, sclk_fall, load_rise, pass;

    always_comb begin
        sclk_rise = sclk_i & ~s_q.sclk_prev;
        sclk_fall = ~sclk_i & s_q.sclk_prev;
        load_rise = load_i & ~s_q.load_prev;
        pass      = ~(cs_gate_i & load_i);

        s_d           = s_q;
        s_d.sclk_prev = sclk_i;
        s_d.load_prev = load_i;
        s_d.commit    = load_rise;
        if (sclk_rise && pass) s_d.sh = {s_q.sh[FRAME_W-2:0], sdin_i};
        if (sclk_fall && pass) s_d.so = s_q.sh[FRAME_W-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign commit_o = s_q.commit;
    assign addr_o   = s_q.sh[ADDR_LSB +: ADDR_W];
    assign data_o   = s_q.sh[DATA_W-1:0];
    assign sdout_o  = s_q.so;

    // R8: deselected clock edges leave the shift register alone
    p_gated_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_gate_i && load_i) |=> $stable(s_q.sh));

    // R4: chain output moves only on falling serial edges
    p_sdout_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sclk_fall |=> $stable(s_q.so));

    // R1: one commit pulse per load edge
    p_commit_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.commit |=> !s_q.commit);
endmodule

// File: rtl/segdrv_regs.sv
module segdrv_regs
    import segdrv_pkg::*;
#(
    parameter int NUM_DIG = 4,
    parameter int SCAN_W  = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  commit_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     data_i,
    output logic [NUM_DIG*8-1:0]  digit_o,
    output logic [NUM_DIG-1:0]    decode_en_o,
    output logic [3:0]            intensity_o,
    output logic [SCAN_W-1:0]     scan_lim_o,
    output logic                  run_o,
    output logic [DATA_W-1:0]     feature_o,
    output logic                  test_o
);
    typedef struct packed {
        logic [NUM_DIG*8-1:0] dig;
        logic [NUM_DIG-1:0]   dec;
        logic [3:0]           bright;
        logic [SCAN_W-1:0]    scan;
        logic                 run;
        logic [DATA_W-1:0]    feat;
        logic                 lamp;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (commit_i) begin
            case (reg_addr_e'(addr_i))
                REG_DECODE: r_d.dec    = data_i[NUM_DIG-1:0];
                REG_BRIGHT: r_d.bright = data_i[3:0];
                REG_SCAN:   r_d.scan   = data_i[SCAN_W-1:0];
                REG_SLEEP: begin
                    r_d.run = data_i[SLP_RUN];
                    if (!data_i[SLP_KEEP_FEAT]) r_d.feat = '0;
                end
                REG_FEAT:   r_d.feat   = data_i;
                REG_LAMP:   r_d.lamp   = data_i[0];
                default: ;
            endcase
            for (int i = 0; i < NUM_DIG; i++) begin
                if (addr_i == REG_DIG_BASE + ADDR_W'(i)) r_d.dig[i*8 +: 8] = data_i;
            end
        end
        if (r_d.feat[FEAT_HOLD_CTL]) begin
            r_d.dec    = '0;
            r_d.bright = '0;
            r_d.scan   = '0;
            r_d.run    = 1'b0;
            r_d.lamp   = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign digit_o     = r_q.dig;
    assign decode_en_o = r_q.dec;
    assign intensity_o = r_q.bright;
    assign scan_lim_o  = r_q.scan;
    assign run_o       = r_q.run;
    assign feature_o   = r_q.feat;
    assign test_o      = r_q.lamp;

    logic ignored_addr;
    assign ignored_addr = (addr_i == REG_NOP) || (addr_i == REG_SPARE) ||
                          ((addr_i > ADDR_W'(NUM_DIG)) && (addr_i < REG_DECODE));

    // R9: digit bytes move only on a commit
    p_digits_need_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !commit_i |=> $stable(r_q.dig));

    // R3: ignored addresses leave every register untouched
    p_ignored_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && ignored_addr) |=> $stable(r_q));

    // R6: sleep-register write with bit 7 set keeps the feature byte
    p_keep_feature_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && addr_i == REG_SLEEP && data_i[SLP_KEEP_FEAT]) |=> $stable(r_q.feat));

    // R6: sleep-register write with bit 7 clear empties the feature byte
    p_clear_feature_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_i && addr_i == REG_SLEEP && !data_i[SLP_KEEP_FEAT]) |=> (r_q.feat == '0));

    // R7: control registers sit at defaults while the hold bit is set
    p_hold_defaults_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.feat[FEAT_HOLD_CTL] |-> (r_q.dec == '0 && r_q.bright == '0 &&
                                     r_q.scan == '0 && !r_q.run && !r_q.lamp));
endmodule

// File: rtl/segdrv_cmd_port.sv
module segdrv_cmd_port
    import segdrv_pkg::*;
#(
    parameter int NUM_DIG = 4,
    localparam int SCAN_W = (NUM_DIG > 1) ? $clog2(NUM_DIG) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 sclk_i,
    input  logic                 sdin_i,
    input  logic                 load_i,
    output logic                 sdout_o,
    output logic [NUM_DIG*8-1:0] digit_o,
    output logic [NUM_DIG-1:0]   decode_en_o,
    output logic [3:0]           intensity_o,
    output logic [SCAN_W-1:0]    scan_lim_o,
    output logic                 run_o,
    output logic [7:0]           feature_o,
    output logic                 test_o
);
    logic [2:0]        pins_sync;
    logic              commit;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;

    segdrv_sync #(.WIDTH(3)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({load_i, sclk_i, sdin_i}),
        .level_o (pins_sync)
    );

    segdrv_shifter u_shifter (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sclk_i    (pins_sync[1]),
        .sdin_i    (pins_sync[0]),
        .load_i    (pins_sync[2]),
        .cs_gate_i (feature_o[FEAT_CS_GATE]),
        .commit_o  (commit),
        .addr_o    (addr),
        .data_o    (data),
        .sdout_o   (sdout_o)
    );

    segdrv_regs #(.NUM_DIG(NUM_DIG), .SCAN_W(SCAN_W)) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .commit_i    (commit),
        .addr_i      (addr),
        .data_i      (data),
        .digit_o     (digit_o),
        .decode_en_o (decode_en_o),
        .intensity_o (intensity_o),
        .scan_lim_o  (scan_lim_o),
        .run_o       (run_o),
        .feature_o   (feature_o),
        .test_o      (test_o)
    );
endmodule

// File: tb/segdrv_cmd_port_bench.sv
module segdrv_cmd_port_bench;
    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdin = 1'b0, load = 1'b1;
    logic        sdout_o, run_o, test_o;
    logic [31:0] digit_o;
    logic [3:0]  decode_en_o, intensity_o;
    logic [1:0]  scan_lim_o;
    logic [7:0]  feature_o;

    always #2 clk = ~clk;

    segdrv_cmd_port u_segdrv_cmd_port (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdin_i(sdin), .load_i(load),
        .sdout_o(sdout_o), .digit_o(digit_o), .decode_en_o(decode_en_o),
        .intensity_o(intensity_o), .scan_lim_o(scan_lim_o), .run_o(run_o),
        .feature_o(feature_o), .test_o(test_o)
    );

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;
    logic [7:0]  e_dig [4];
    logic [3:0]  e_dec, e_int;
    logic [1:0]  e_scan;
    logic        e_run, e_test, e_so;
    logic [7:0]  e_feat;
    logic [15:0] m_sh;
    logic        exp_q [$];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 4; i++) check(req, $sformatf("digit%0d", i), digit_o[i*8 +: 8], e_dig[i]);
        check(req, "decode", decode_en_o, e_dec);
        check(req, "intensity", intensity_o, e_int);
        check(req, "scan", scan_lim_o, e_scan);
        check(req, "run", run_o, e_run);
        check(req, "feature", feature_o, e_feat);
        check(req, "test", test_o, e_test);
    endtask

    // independent model of the register rules (R2, R3, R6, R7)
    task automatic model_apply(input logic [3:0] a, input logic [7:0] d);
        case (a)
            4'h1, 4'h2, 4'h3, 4'h4: e_dig[a-1] = d;
            4'h9: e_dec  = d[3:0];
            4'hA: e_int  = d[3:0];
            4'hB: e_scan = d[1:0];
            4'hC: begin e_run = d[0]; if (!d[7]) e_feat = 8'h00; end
            4'hE: e_feat = d;
            4'hF: e_test = d[0];
            default: ;
        endcase
        if (e_feat[1]) begin
            e_dec = 0; e_int = 0; e_scan = 0; e_run = 0; e_test = 0;
        end
    endtask

    task automatic send_bit(input logic b);
        logic pass;
        @(negedge clk);
        sdin = b;
        repeat (6) @(negedge clk);
        pass = !(e_feat[3] && load);
        sclk = 1'b1;
        if (pass) m_sh = {m_sh[14:0], b};
        repeat (6) @(negedge clk);
        if (pass) e_so = m_sh[15];
        exp_q.push_back(e_so);
        sclk = 1'b0;
    endtask

    task automatic shift_bits(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic drop_load;
        @(negedge clk);
        load = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic raise_load;
        repeat (6) @(negedge clk);
        load = 1'b1;
        repeat (14) @(negedge clk);
    endtask

    task automatic write(input logic [3:0] hi, input logic [3:0] a, input logic [7:0] d);
        drop_load;
        shift_bits({hi, a, d}, 16);
        raise_load;
        model_apply(a, d);
    endtask

    // scoreboard monitor for the chain output (R4)
    initial begin
        forever begin
            @(negedge sclk);
            repeat (5) @(posedge clk);
            @(negedge clk);
            if (exp_q.size() > 0) check("R4", "sdout", sdout_o, exp_q.pop_front());
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog (R1..all): actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) e_dig[i] = 8'h00;
        e_dec = 0; e_int = 0; e_scan = 0; e_run = 0; e_feat = 0; e_test = 0;
        e_so = 0; m_sh = 0;
        repeat (8) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R5: power-up values
        check_regs("R5");
        check("R5", "sdout", sdout_o, 1'b0);

        // R1/R2: digit writes, upper nibble is junk
        write(4'hA, 4'h1, 8'h12);
        write(4'h5, 4'h2, 8'h34);
        write(4'hF, 4'h3, 8'hC7);
        write(4'h0, 4'h4, 8'h80);
        check_regs("R1");

        // R2: control registers, only the stated data bits land
        write(4'h3, 4'h9, 8'hFF);
        write(4'h0, 4'hA, 8'h3C);
        write(4'h0, 4'hB, 8'h07);
        write(4'h0, 4'hF, 8'h01);
        write(4'h0, 4'hC, 8'h81);
        check_regs("R2");

        // R3: no-op, unused and spare addresses
        write(4'h0, 4'h0, 8'h55);
        write(4'h0, 4'h5, 8'h99);
        write(4'h0, 4'h8, 8'h11);
        write(4'h0, 4'hD, 8'hEE);
        check_regs("R3");

        // R6: sleep write keeps or clears the feature byte
        write(4'h0, 4'hE, 8'h30);
        write(4'h0, 4'hC, 8'h80);
        check_regs("R6");
        check("R6", "feature kept", feature_o, 8'h30);
        write(4'h0, 4'hC, 8'h01);
        check_regs("R6");
        check("R6", "feature cleared", feature_o, 8'h00);

        // R7: hold bit forces control defaults, digits survive
        write(4'h0, 4'hA, 8'h07);
        write(4'h0, 4'hE, 8'h02);
        check_regs("R7");
        write(4'h0, 4'hA, 8'h05);
        check("R7", "intensity held", intensity_o, 4'h0);
        write(4'h0, 4'hE, 8'h00);
        write(4'h0, 4'hA, 8'h05);
        check_regs("R7");

        // R9 then R1: 20 bits without a load edge, then commit the last 16
        drop_load;
        shift_bits(16'h000F, 4);
        shift_bits(16'h0_2_6B, 16);
        repeat (14) @(negedge clk);
        check_regs("R9");
        raise_load;
        model_apply(4'h2, 8'h6B);
        check_regs("R1");
        check("R1", "last 16 bits", digit_o[15:8], 8'h6B);

        // R8: select gating ignores clocks while load is high
        write(4'h0, 4'hE, 8'h08);
        write(4'h0, 4'h1, 8'h5A);
        shift_bits(16'h0_2_33, 16);
        repeat (14) @(negedge clk);
        check_regs("R8");
        drop_load;
        raise_load;
        model_apply(4'h1, 8'h5A);
        check_regs("R8");
        check("R8", "digit1 untouched", digit_o[15:8], 8'h6B);

        repeat (20) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule